// File: doc/BRIEF.md
# Interrupt Target Resolver

This block decides which of a set of agents an interrupt command reaches. A command carries an 8-bit destination, a bit choosing physical or logical addressing, a 2-bit shorthand that can override the destination entirely, the index of the agent sending it, and a flag asking for lowest-priority delivery. Each agent describes itself to the block with a present bit, an 8-bit ID, an 8-bit logical address and a 4-bit logical model code. From these the block builds an N-bit delivery mask, one bit per agent.

When lowest-priority delivery is requested, the block also returns a one-hot vector that names a single agent: the lowest-numbered one in the mask. All per-agent decisions are made in parallel. The result is registered and appears one cycle after the command strobe, together with a one-cycle valid flag. Moving the message to the agents and how each agent accepts it are handled elsewhere.

Top module: `irq_target_resolver`

## Requirements
- R1: The shorthand is decoded as follows. 0 uses the destination and addressing mode. 1 selects only the sender. 2 selects every agent including the sender. 3 selects every agent except the sender. For shorthands 1 to 3, the destination and mode bit have no effect.
- R2: With physical addressing (mode bit 0) and destination 8'hFF, every agent is selected.
- R3: With physical addressing and any other destination, exactly the agents whose ID equals the destination are selected.
- R4: With logical addressing (mode bit 1), an agent whose model code is 4'hF matches when the bitwise AND of the destination and its logical address is nonzero.
- R5: With logical addressing, an agent whose model code is 4'h0 matches when the upper nibble (bits 7:4) of the destination equals the upper nibble of its logical address and the lower nibbles (bits 3:0) have at least one set bit in common.
- R6: With logical addressing, an agent with any model code other than 4'hF or 4'h0 never matches.
- R7: An agent whose present bit is 0 is never in the mask, under any shorthand or mode.
- R8: When lowest-priority delivery is requested, the pick output is one-hot on the lowest-numbered set bit of the mask. The pick output is all zero when the mask is empty or when lowest-priority delivery was not requested.
- R9: The mask and pick are registered at the clock edge where cmd_valid is high and appear one cycle later. res_valid is high for exactly that cycle. Between commands, the mask and pick hold their last values.
- R10: After reset, res_valid, res_mask and res_pick are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_dest | input | 8 | Destination field |
| cmd_logical | input | 1 | 0 physical, 1 logical addressing |
| cmd_shorthand | input | 2 | Destination override code |
| cmd_lowpri | input | 1 | Request single lowest-priority target |
| cmd_sender | input | IDX_W | Index of the sending agent |
| agent_present | input | N_AGENTS | Agent k exists |
| agent_id | input | 8*N_AGENTS | Agent k ID in bits 8k+7:8k |
| agent_ldest | input | 8*N_AGENTS | Agent k logical address in bits 8k+7:8k |
| agent_model | input | 4*N_AGENTS | Agent k model code in bits 4k+3:4k |
| res_valid | output | 1 | Result valid, one cycle |
| res_mask | output | N_AGENTS | Delivery mask |
| res_pick | output | N_AGENTS | One-hot lowest-priority target |

## Verification
Physical commands are tried with the broadcast value, with an ID shared by two agents, and with an ID no agent has. These tell equality matching apart from broadcast and show that a miss gives an empty mask. Logical commands are applied with all agents flat, all clustered, and with a mix that includes unknown model codes. This separates the AND test from the nibble test, and shows that unknown codes never match. Each shorthand is issued with a destination that would select other agents, which shows the destination is ignored. Absent agents are placed on the sender index and on broadcast targets, and lowest-priority picks are checked on sparse, full and empty masks.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [7:0] PHYS_BCAST    = 8'hFF;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  // Physical addressing: broadcast or exact ID equality
  function automatic logic physical_hit(input logic [7:0] dest, input logic [7:0] id);
    return (dest == PHYS_BCAST) || (dest == id);
  endfunction

  // Logical addressing: flat uses a full-byte overlap, cluster matches the
  // high nibble and needs overlap in the low nibble
  function automatic logic logical_hit(input logic [7:0] dest, input logic [7:0] ldest,
                                       input logic [3:0] model);
    logic hit;
    case (model)
      MODEL_FLAT:    hit = |(dest & ldest);
      MODEL_CLUSTER: hit = (dest[7:4] == ldest[7:4]) && |(dest[3:0] & ldest[3:0]);
      default:       hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/agent_matcher.sv
module agent_matcher
  import irq_route_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int IDX   = 0
) (
  input  logic [7:0]       dest,
  input  logic             logical,
  input  logic [1:0]       shorthand,
  input  logic [IDX_W-1:0] sender,
  input  logic             present,
  input  logic [7:0]       id,
  input  logic [7:0]       ldest,
  input  logic [3:0]       model,
  output logic             hit
);

  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX);

  logic field_hit;
  logic is_sender;
  logic raw_hit;

  assign field_hit = logical ? logical_hit(dest, ldest, model) : physical_hit(dest, id);
  assign is_sender = (sender == MY_IDX);

  always_comb begin
    case (shorthand_e'(shorthand))
      SH_FIELD:  raw_hit = field_hit;
      SH_SELF:   raw_hit = is_sender;
      SH_ALL:    raw_hit = 1'b1;
      SH_OTHERS: raw_hit = !is_sender;
      default:   raw_hit = 1'b0;
    endcase
  end

  assign hit = present && raw_hit;

endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] onehot
);

  // Isolate the lowest set bit by two's complement
  assign onehot = vec & (~vec + N'(1));

endmodule

// File: rtl/irq_target_resolver.sv
module irq_target_resolver #(
  parameter int N_AGENTS = 8,
  localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [7:0]              cmd_dest,
  input  logic                    cmd_logical,
  input  logic [1:0]              cmd_shorthand,
  input  logic                    cmd_lowpri,
  input  logic [IDX_W-1:0]        cmd_sender,
  input  logic [N_AGENTS-1:0]     agent_present,
  input  logic [8*N_AGENTS-1:0]   agent_id,
  input  logic [8*N_AGENTS-1:0]   agent_ldest,
  input  logic [4*N_AGENTS-1:0]   agent_model,
  output logic                    res_valid,
  output logic [N_AGENTS-1:0]     res_mask,
  output logic [N_AGENTS-1:0]     res_pick
);

  logic [N_AGENTS-1:0] match_now;
  logic [N_AGENTS-1:0] lowest_now;
  logic [N_AGENTS-1:0] pick_now;

  for (genvar k = 0; k < N_AGENTS; k++) begin : g_agent
    agent_matcher #(.IDX_W(IDX_W), .IDX(k)) u_match (
      .dest      (cmd_dest),
      .logical   (cmd_logical),
      .shorthand (cmd_shorthand),
      .sender    (cmd_sender),
      .present   (agent_present[k]),
      .id        (agent_id[8*k +: 8]),
      .ldest     (agent_ldest[8*k +: 8]),
      .model     (agent_model[4*k +: 4]),
      .hit       (match_now[k])
    );
  end

  lowest_pick #(.N(N_AGENTS)) u_pick (
    .vec    (match_now),
    .onehot (lowest_now)
  );

  assign pick_now = cmd_lowpri ? lowest_now : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_mask  <= '0;
      res_pick  <= '0;
    end else begin
      res_valid <= cmd_valid;
      if (cmd_valid) begin
        res_mask <= match_now;
        res_pick <= pick_now;
      end
    end
  end

endmodule

// File: rtl/irq_target_resolver_chk.sv
module irq_target_resolver_chk #(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [1:0]          cmd_shorthand,
  input logic [IDX_W-1:0]    cmd_sender,
  input logic [N_AGENTS-1:0] agent_present,
  input logic                res_valid,
  input logic [N_AGENTS-1:0] res_mask,
  input logic [N_AGENTS-1:0] res_pick
);

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> res_valid);

  p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !res_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(res_mask) && $stable(res_pick)));

  p_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> ((res_mask & ~$past(agent_present)) == '0));

  p_self_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_shorthand == 2'd1) |=> ($countones(res_mask) <= 1));

  p_others_skip_sender_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_shorthand == 2'd3) |=> !res_mask[$past(cmd_sender)]);

  p_pick_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_pick));

  p_pick_in_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_pick & ~res_mask) == '0);

  p_pick_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_pick != '0) |-> (((res_pick - N_AGENTS'(1)) & res_mask) == '0));

endmodule

bind irq_target_resolver irq_target_resolver_chk #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_shorthand (cmd_shorthand),
  .cmd_sender    (cmd_sender),
  .agent_present (agent_present),
  .res_valid     (res_valid),
  .res_mask      (res_mask),
  .res_pick      (res_pick)
);

// File: tb/irq_target_resolver_tb.sv
module irq_target_resolver_tb;

  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [7:0]   cmd_dest = '0;
  logic         cmd_logical = 1'b0;
  logic [1:0]   cmd_shorthand = '0;
  logic         cmd_lowpri = 1'b0;
  logic [W-1:0] cmd_sender = '0;
  logic [N-1:0] agent_present = '1;
  logic [8*N-1:0] agent_id;
  logic [8*N-1:0] agent_ldest;
  logic [4*N-1:0] agent_model;
  logic         res_valid;
  logic [N-1:0] res_mask;
  logic [N-1:0] res_pick;

  logic [7:0] tb_id [N];
  logic [7:0] tb_ld [N];
  logic [3:0] tb_md [N];

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      agent_id[8*k +: 8]    = tb_id[k];
      agent_ldest[8*k +: 8] = tb_ld[k];
      agent_model[4*k +: 4] = tb_md[k];
    end
  end

  irq_target_resolver #(.N_AGENTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dest(cmd_dest),
    .cmd_logical(cmd_logical), .cmd_shorthand(cmd_shorthand), .cmd_lowpri(cmd_lowpri),
    .cmd_sender(cmd_sender), .agent_present(agent_present), .agent_id(agent_id),
    .agent_ldest(agent_ldest), .agent_model(agent_model), .res_valid(res_valid),
    .res_mask(res_mask), .res_pick(res_pick)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model, written from the requirements
  function automatic logic [N-1:0] ref_mask(input logic [7:0] d, input logic lg,
                                            input logic [1:0] sh, input int snd);
    logic [N-1:0] m;
    for (int k = 0; k < N; k++) begin
      logic sel;
      if (sh == 2'd1)      sel = (k == snd);
      else if (sh == 2'd2) sel = 1'b1;
      else if (sh == 2'd3) sel = (k != snd);
      else if (!lg)        sel = (d == 8'hFF) || (tb_id[k] == d);
      else if (tb_md[k] == 4'hF) sel = (d & tb_ld[k]) != 8'h00;
      else if (tb_md[k] == 4'h0) sel = (d[7:4] == tb_ld[k][7:4]) && ((d[3:0] & tb_ld[k][3:0]) != 4'h0);
      else                 sel = 1'b0;
      m[k] = sel && agent_present[k];
    end
    return m;
  endfunction

  function automatic logic [N-1:0] ref_pick(input logic [N-1:0] m, input logic lp);
    logic [N-1:0] p = '0;
    if (lp) begin
      for (int k = N - 1; k >= 0; k--) if (m[k]) p = '0 | (N'(1) << k);
    end
    return p;
  endfunction

  task automatic issue(input string tag, input logic [7:0] d, input logic lg,
                       input logic [1:0] sh, input logic lp, input int snd);
    logic [N-1:0] em, ep;
    @(negedge clk);
    cmd_dest = d; cmd_logical = lg; cmd_shorthand = sh; cmd_lowpri = lp;
    cmd_sender = W'(snd); cmd_valid = 1'b1;
    em = ref_mask(d, lg, sh, snd);
    ep = ref_pick(em, lp);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " R9 valid"}, 32'(res_valid), 32'd1);
    chk({tag, " mask"}, 32'(res_mask), 32'(em));
    chk({tag, " R8 pick"}, 32'(res_pick), 32'(ep));
  endtask

  task automatic setup_phys();
    for (int k = 0; k < N; k++) begin
      tb_id[k] = 8'h20 + 8'(k); tb_ld[k] = 8'h00; tb_md[k] = 4'hF;
    end
    tb_id[5] = 8'h22;
    agent_present = '1;
  endtask

  task automatic t_reset();
    chk("R10 valid", 32'(res_valid), 32'd0);
    chk("R10 mask", 32'(res_mask), 32'd0);
    chk("R10 pick", 32'(res_pick), 32'd0);
  endtask

  task automatic t_physical();
    setup_phys();
    issue("R2 broadcast", 8'hFF, 1'b0, 2'd0, 1'b0, 0);
    chk("R2 all set", 32'(res_mask), 32'hFF);
    issue("R3 shared id", 8'h22, 1'b0, 2'd0, 1'b0, 0);
    chk("R3 two hits", 32'(res_mask), 32'h24);
    issue("R3 single id", 8'h27, 1'b0, 2'd0, 1'b0, 0);
    issue("R3 no id", 8'h99, 1'b0, 2'd0, 1'b0, 0);
    chk("R3 empty", 32'(res_mask), 32'h00);
  endtask

  task automatic t_shorthand();
    setup_phys();
    issue("R1 self", 8'h20, 1'b0, 2'd1, 1'b0, 6);
    chk("R1 self only", 32'(res_mask), 32'h40);
    issue("R1 all", 8'h21, 1'b1, 2'd2, 1'b0, 6);
    chk("R1 all incl", 32'(res_mask), 32'hFF);
    issue("R1 others", 8'h26, 1'b0, 2'd3, 1'b0, 6);
    chk("R1 others excl", 32'(res_mask), 32'hBF);
  endtask

  task automatic t_flat();
    for (int k = 0; k < N; k++) begin
      tb_ld[k] = 8'(1 << k); tb_md[k] = 4'hF;
    end
    issue("R4 flat", 8'h24, 1'b1, 2'd0, 1'b0, 0);
    chk("R4 flat bits", 32'(res_mask), 32'h24);
    issue("R4 flat none", 8'h00, 1'b1, 2'd0, 1'b0, 0);
  endtask

  task automatic t_cluster();
    for (int k = 0; k < N; k++) begin
      tb_ld[k] = {4'(k / 4 + 1), 4'(1 << (k % 4))}; tb_md[k] = 4'h0;
    end
    issue("R5 cluster", 8'h23, 1'b1, 2'd0, 1'b0, 0);
    chk("R5 cluster bits", 32'(res_mask), 32'h30);
    issue("R5 wrong cluster", 8'h33, 1'b1, 2'd0, 1'b0, 0);
    chk("R5 cluster miss", 32'(res_mask), 32'h00);
  endtask

  task automatic t_other_model();
    for (int k = 0; k < N; k++) begin
      tb_ld[k] = 8'hFF; tb_md[k] = (k % 3 == 0) ? 4'h5 : ((k % 3 == 1) ? 4'hF : 4'h0);
    end
    tb_ld[2] = 8'h1F; tb_ld[5] = 8'h1F; tb_ld[4] = 8'h01; tb_ld[7] = 8'h02;
    issue("R6 mixed", 8'h11, 1'b1, 2'd0, 1'b0, 0);
    chk("R6 unknown excluded", 32'(res_mask), 32'h36);
  endtask

  task automatic t_absent();
    setup_phys();
    agent_present = 8'b1101_0110;
    issue("R7 self absent", 8'h00, 1'b0, 2'd1, 1'b0, 0);
    chk("R7 self absent empty", 32'(res_mask), 32'h00);
    issue("R7 bcast", 8'hFF, 1'b0, 2'd0, 1'b0, 0);
    chk("R7 bcast present", 32'(res_mask), 32'hD6);
    issue("R7 all", 8'h00, 1'b0, 2'd2, 1'b1, 1);
    agent_present = '1;
  endtask

  task automatic t_lowpri();
    setup_phys();
    issue("R8 sparse", 8'h22, 1'b0, 2'd0, 1'b1, 0);
    chk("R8 lowest of two", 32'(res_pick), 32'h04);
    issue("R8 full", 8'hFF, 1'b0, 2'd0, 1'b1, 0);
    chk("R8 lowest of all", 32'(res_pick), 32'h01);
    issue("R8 empty", 8'h99, 1'b0, 2'd0, 1'b1, 0);
    issue("R8 not lowpri", 8'hFF, 1'b0, 2'd3, 1'b0, 0);
    chk("R8 pick zero", 32'(res_pick), 32'h00);
  endtask

  task automatic t_timing();
    logic [N-1:0] held;
    setup_phys();
    issue("R9 base", 8'h23, 1'b0, 2'd0, 1'b1, 0);
    held = res_mask;
    cmd_dest = 8'hFF;
    @(negedge clk);
    chk("R9 valid drops", 32'(res_valid), 32'd0);
    chk("R9 mask held", 32'(res_mask), 32'(held));
    chk("R9 pick held", 32'(res_pick), 32'h08);
  endtask

  initial begin
    setup_phys();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_physical();
    t_shorthand();
    t_flat();
    t_cluster();
    t_other_model();
    t_absent();
    t_lowpri();
    t_timing();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule